// File: doc/BRIEF.md
# Configurable Edge/Level Interrupt Controller

This block collects 32 interrupt lines and turns them into two request outputs and one wake output. Each line can come from one of two input banks (an internal bank and an external bank). Each line is given a trigger mode through a 3-bit code. The code can select a rising edge, a falling edge, either edge, an active-high level or an active-low level, or it can turn the line off. Edges are latched in two capture registers, one for rising events and one for falling events. A latched edge stays pending until software clears it. A level source is pending for as long as its input holds the active polarity.

Software controls the block through a single-cycle register bus. Every control register has its own set address and its own clear address. At either address, a 1 in the write data acts on that bit and a 0 leaves the bit as it is. A read address returns the register's current value. Two status registers show, for each request output, the pending sources that are unmasked and routed to it. A system that needs 64 lines uses two instances. Source n at or above 32 then maps to bit n−32 of the second instance.

Top module: `intc_top`

## Requirements
- R1: After reset the three mode registers, the mask, the wake enables, both capture registers and the test register are all zero. The bank-select and routing registers are all ones. All three outputs are low.
- R2: The bus address is {reg[3:0], op[1:0]}. The op field means 0 = read, 1 = set, 2 = clear, 3 = load. The reg numbers are:
  - 0, 1, 2: mode bit 0, bit 1 and bit 2
  - 3: bank select
  - 4: routing
  - 5: wake enable
  - 6: mask
  - 7: rising capture
  - 8: falling capture
  - 9: request-0 status
  - 10: request-1 status
  - 11: test

  For reg 0 to 6, a set write ORs the data into the register, a clear write removes the 1 bits of the data, and a read returns the value.
- R3: The mode of source n is {mode2[n], mode1[n], mode0[n]}. Code 001 is a rising edge, 010 a falling edge, 011 either edge, 101 an active-high level and 110 an active-low level. Codes 000, 100 and 111 never make the source pending. An edge of a direction the mode does not select is not captured.
- R4: An enabled edge sets the matching capture bit. The bit stays set until a 1 is written to it at the clear op of reg 7 (rising) or reg 8 (falling). If the edge arrives in the same cycle as the clear write, the capture bit ends up set.
- R5: A level-mode source is pending exactly while its synchronised input matches the mode's polarity. It never sets a capture bit.
- R6: req0_o is high when a source is pending, masked-in (mask = 1) and has routing = 1. req1_o is the same with routing = 0. Status regs 9 and 10 read back those per-source vectors.
- R7: wake_o is high when any pending source has its wake-enable bit set. This holds whatever the mask is.
- R8: A bank-select bit of 1 takes the source from src_int_i, and a bit of 0 takes it from src_ext_i.
- R9: Read data appears on bus_rdata_o in the cycle after the read. It is zero after any cycle that was not a read at op 0, and zero for unmapped regs.
- R10: An input change reaches a level-mode pending state after two clock edges. An edge reaches its capture bit at the third edge.
- R11: The test register resets to zero, is written only by a load op (op 3) on reg 11, and reads back the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Bus access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | {reg, op} address |
| bus_wdata_i | input | 32 | Write data, one bit per source |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| src_int_i | input | 32 | Internal-bank interrupt lines |
| src_ext_i | input | 32 | External-bank interrupt lines |
| req0_o | output | 1 | Request output 0 |
| req1_o | output | 1 | Request output 1 |
| wake_o | output | 1 | Wake output |

## Verification
The hardest case to reach from the ports is a clear write that meets a fresh edge in the same cycle. The bench counts the synchroniser and edge-detector stages, then places the clear write on the exact edge where the event is detected. It expects the capture bit to survive. A second hard case is changing the bank select while a level source is active. The bench checks that the request follows the newly selected bank at once, with no capture left behind. A cycle-accurate behavioural model runs next to the design and compares all outputs every cycle.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int REG_W  = 4;
    localparam int OP_W   = 2;
    localparam int ADDR_W = REG_W + OP_W;
    localparam int CTL_N  = 7;

    typedef enum logic [OP_W-1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_LOAD = 2'd3
    } op_e;

    typedef enum logic [REG_W-1:0] {
        RG_MODE0 = 4'd0,
        RG_MODE1 = 4'd1,
        RG_MODE2 = 4'd2,
        RG_BANK  = 4'd3,
        RG_ROUTE = 4'd4,
        RG_WAKE  = 4'd5,
        RG_MASK  = 4'd6,
        RG_RISE  = 4'd7,
        RG_FALL  = 4'd8,
        RG_STAT0 = 4'd9,
        RG_STAT1 = 4'd10,
        RG_TEST  = 4'd11
    } reg_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic hi;
        logic lo;
    } trig_t;

    function automatic trig_t decode_mode(input logic [2:0] code);
        trig_t t;
        t.rise = (code == 3'b001) || (code == 3'b011);
        t.fall = (code == 3'b010) || (code == 3'b011);
        t.hi   = (code == 3'b101);
        t.lo   = (code == 3'b110);
        return t;
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] st1_q;
    logic [W-1:0] st2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1_q <= '0;
            st2_q <= '0;
        end else begin
            st1_q <= d_i;
            st2_q <= st1_q;
        end
    end

    assign q_o = st2_q;
endmodule

// File: rtl/intc_chan.sv
module intc_chan
    import intc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] mode_i,
    input  logic       bank_i,
    input  logic       int_i,
    input  logic       ext_i,
    input  logic       clr_rise_i,
    input  logic       clr_fall_i,
    output logic       pend_o,
    output logic       rise_o,
    output logic       fall_o
);
    trig_t trig;
    logic  line;
    logic  prev_q;
    logic  rise_ev;
    logic  fall_ev;

    assign trig    = decode_mode(mode_i);
    assign line    = bank_i ? int_i : ext_i;
    assign rise_ev = trig.rise &  line & ~prev_q;
    assign fall_ev = trig.fall & ~line &  prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            prev_q <= line;
            rise_o <= (rise_o & ~clr_rise_i) | rise_ev;
            fall_o <= (fall_o & ~clr_fall_i) | fall_ev;
        end
    end

    assign pend_o = (trig.rise & rise_o) | (trig.fall & fall_o)
                  | (trig.hi & line) | (trig.lo & ~line);

    AST_RISE_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (rise_o && !$past(rise_o)) |-> $past(trig.rise)); // R4
    AST_FALL_NEEDS_MODE: assert property (@(posedge clk) disable iff (rst)
        (fall_o && !$past(fall_o)) |-> $past(trig.fall)); // R4
    AST_CAPTURE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rise_o && !clr_rise_i) |=> rise_o); // R4
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid_i,
    input  logic              bus_we_i,
    input  logic [5:0]        bus_addr_i,
    input  logic [NSRC-1:0]   bus_wdata_i,
    output logic [NSRC-1:0]   bus_rdata_o,
    input  logic [NSRC-1:0]   src_int_i,
    input  logic [NSRC-1:0]   src_ext_i,
    output logic              req0_o,
    output logic              req1_o,
    output logic              wake_o
);
    localparam int BANK_IX  = int'(RG_BANK);
    localparam int ROUTE_IX = int'(RG_ROUTE);
    localparam int WAKE_IX  = int'(RG_WAKE);
    localparam int MASK_IX  = int'(RG_MASK);

    logic [NSRC-1:0] ctl_q [CTL_N];
    logic [NSRC-1:0] test_q;
    logic [NSRC-1:0] int_s, ext_s;
    logic [NSRC-1:0] pend, rise_q, fall_q;
    logic [NSRC-1:0] clr_rise, clr_fall;
    logic [NSRC-1:0] stat0, stat1;
    logic [REG_W-1:0] rsel;
    op_e             op;
    logic            wr, rd;

    assign rsel = bus_addr_i[ADDR_W-1:OP_W];
    assign op   = op_e'(bus_addr_i[OP_W-1:0]);
    assign wr   = bus_valid_i &  bus_we_i;
    assign rd   = bus_valid_i & ~bus_we_i;

    assign clr_rise = (wr && rsel == RG_RISE && op == OP_CLR) ? bus_wdata_i : '0;
    assign clr_fall = (wr && rsel == RG_FALL && op == OP_CLR) ? bus_wdata_i : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CTL_N; i++) begin
                ctl_q[i] <= (i == BANK_IX || i == ROUTE_IX) ? '1 : '0;
            end
            test_q <= '0;
        end else if (wr) begin
            for (int i = 0; i < CTL_N; i++) begin
                if (rsel == REG_W'(i)) begin
                    if (op == OP_SET) ctl_q[i] <= ctl_q[i] | bus_wdata_i;
                    if (op == OP_CLR) ctl_q[i] <= ctl_q[i] & ~bus_wdata_i;
                end
            end
            if (rsel == RG_TEST && op == OP_LOAD) test_q <= bus_wdata_i;
        end
    end

    intc_sync #(.W(NSRC)) u_sync_int (.clk(clk), .rst(rst), .d_i(src_int_i), .q_o(int_s));
    intc_sync #(.W(NSRC)) u_sync_ext (.clk(clk), .rst(rst), .d_i(src_ext_i), .q_o(ext_s));

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        intc_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .mode_i    ({ctl_q[int'(RG_MODE2)][g], ctl_q[int'(RG_MODE1)][g], ctl_q[int'(RG_MODE0)][g]}),
            .bank_i    (ctl_q[BANK_IX][g]),
            .int_i     (int_s[g]),
            .ext_i     (ext_s[g]),
            .clr_rise_i(clr_rise[g]),
            .clr_fall_i(clr_fall[g]),
            .pend_o    (pend[g]),
            .rise_o    (rise_q[g]),
            .fall_o    (fall_q[g])
        );
    end

    assign stat0  = pend & ctl_q[MASK_IX] &  ctl_q[ROUTE_IX];
    assign stat1  = pend & ctl_q[MASK_IX] & ~ctl_q[ROUTE_IX];
    assign req0_o = |stat0;
    assign req1_o = |stat1;
    assign wake_o = |(pend & ctl_q[WAKE_IX]);

    always_ff @(posedge clk) begin
        if (rst || !rd || op != OP_READ) begin
            bus_rdata_o <= '0;
        end else begin
            case (rsel)
                RG_MODE0, RG_MODE1, RG_MODE2, RG_BANK,
                RG_ROUTE, RG_WAKE, RG_MASK: bus_rdata_o <= ctl_q[rsel[2:0]];
                RG_RISE:  bus_rdata_o <= rise_q;
                RG_FALL:  bus_rdata_o <= fall_q;
                RG_STAT0: bus_rdata_o <= stat0;
                RG_STAT1: bus_rdata_o <= stat1;
                RG_TEST:  bus_rdata_o <= test_q;
                default:  bus_rdata_o <= '0;
            endcase
        end
    end

    AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (req0_o || req1_o) |-> (ctl_q[MASK_IX] != '0)); // R6
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (ctl_q[WAKE_IX] != '0)); // R7
    AST_RD_SETCLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd && (op == OP_SET || op == OP_CLR)) |=> (bus_rdata_o == '0)); // R9
    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_valid_i |=> (bus_rdata_o == '0)); // R9
endmodule

// File: tb/tb_intc_top.sv
module tb_intc_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid_i = 1'b0;
    logic          bus_we_i = 1'b0;
    logic [5:0]    bus_addr_i = '0;
    logic [N-1:0]  bus_wdata_i = '0;
    logic [N-1:0]  bus_rdata_o;
    logic [N-1:0]  src_int_i = '0;
    logic [N-1:0]  src_ext_i = '0;
    logic          req0_o, req1_o, wake_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    intc_top dut (
        .clk(clk), .rst(rst), .bus_valid_i(bus_valid_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .src_int_i(src_int_i), .src_ext_i(src_ext_i),
        .req0_o(req0_o), .req1_o(req1_o), .wake_o(wake_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [N-1:0] m_ctl [7];
    logic [N-1:0] m_rise, m_fall, m_test, m_rd;
    logic [N-1:0] m_i1, m_i2, m_e1, m_e2, m_prev;

    function automatic logic [N-1:0] m_line();
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = m_ctl[3][i] ? m_i2[i] : m_e2[i];
        return v;
    endfunction

    function automatic int m_code(input int i);
        return {m_ctl[2][i], m_ctl[1][i], m_ctl[0][i]};
    endfunction

    function automatic logic [N-1:0] m_pend();
        logic [N-1:0] v, ln;
        ln = m_line();
        for (int i = 0; i < N; i++) begin
            case (m_code(i))
                1: v[i] = m_rise[i];
                2: v[i] = m_fall[i];
                3: v[i] = m_rise[i] | m_fall[i];
                5: v[i] = ln[i];
                6: v[i] = ~ln[i];
                default: v[i] = 1'b0;
            endcase
        end
        return v;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] ln, er, ef, cr, cf, p;
        int r, o;
        if (rst) begin
            for (int k = 0; k < 7; k++) m_ctl[k] = (k == 3 || k == 4) ? '1 : '0;
            m_rise = '0; m_fall = '0; m_test = '0; m_rd = '0;
            m_i1 = '0; m_i2 = '0; m_e1 = '0; m_e2 = '0; m_prev = '0;
        end else begin
            ln = m_line();
            p  = m_pend();
            r  = int'(bus_addr_i[5:2]);
            o  = int'(bus_addr_i[1:0]);
            for (int i = 0; i < N; i++) begin
                int c;
                c = m_code(i);
                er[i] = (c == 1 || c == 3) && ln[i] && !m_prev[i];
                ef[i] = (c == 2 || c == 3) && !ln[i] && m_prev[i];
            end
            m_rd = '0;
            if (bus_valid_i && !bus_we_i && o == 0) begin
                if (r <= 6) m_rd = m_ctl[r];
                else if (r == 7) m_rd = m_rise;
                else if (r == 8) m_rd = m_fall;
                else if (r == 9) m_rd = p & m_ctl[6] & m_ctl[4];
                else if (r == 10) m_rd = p & m_ctl[6] & ~m_ctl[4];
                else if (r == 11) m_rd = m_test;
            end
            cr = '0; cf = '0;
            if (bus_valid_i && bus_we_i) begin
                if (r <= 6 && o == 1) m_ctl[r] = m_ctl[r] | bus_wdata_i;
                if (r <= 6 && o == 2) m_ctl[r] = m_ctl[r] & ~bus_wdata_i;
                if (r == 7 && o == 2) cr = bus_wdata_i;
                if (r == 8 && o == 2) cf = bus_wdata_i;
                if (r == 11 && o == 3) m_test = bus_wdata_i;
            end
            m_rise = (m_rise & ~cr) | er;
            m_fall = (m_fall & ~cf) | ef;
            m_prev = ln;
            m_i2 = m_i1; m_i1 = src_int_i;
            m_e2 = m_e1; m_e1 = src_ext_i;
        end
    end

    always @(negedge clk) begin
        logic [N-1:0] p;
        if (!rst && !done) begin
            p = m_pend();
            chk("R6 req0 model", N'(req0_o), N'(|(p & m_ctl[6] & m_ctl[4])));
            chk("R6 req1 model", N'(req1_o), N'(|(p & m_ctl[6] & ~m_ctl[4])));
            chk("R7 wake model", N'(wake_o), N'(|(p & m_ctl[5])));
            chk("R9 rdata model", bus_rdata_o, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input int r, input int o, input logic [N-1:0] d);
        bus_valid_i = 1'b1; bus_we_i = 1'b1;
        bus_addr_i = {4'(r), 2'(o)}; bus_wdata_i = d;
        @(posedge clk); #1;
        bus_valid_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic rd(input int r, input int o, output logic [N-1:0] v);
        bus_valid_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = {4'(r), 2'(o)};
        @(posedge clk); #1;
        bus_valid_i = 1'b0;
        v = bus_rdata_o;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 req0", N'(req0_o), '0);
        chk("R1 wake", N'(wake_o), '0);
        for (int r = 0; r < 12; r++) begin
            if (r == 9 || r == 10) continue;
            rd(r, 0, v);
            chk("R1 reset reg", v, (r == 3 || r == 4) ? '1 : '0);
        end

        // R2 set / clear semantics
        wr(0, 1, 32'h0000_00F0);
        wr(0, 2, 32'h0000_0030);
        wr(0, 1, 32'h0);
        rd(0, 0, v); chk("R2 set/clr", v, 32'h0000_00C0);
        wr(0, 2, '1);
        rd(0, 0, v); chk("R2 clear all", v, '0);

        // R9 set/clr and unmapped addresses read zero
        rd(6, 1, v); chk("R9 read of set addr", v, '0);
        rd(14, 0, v); chk("R9 unmapped", v, '0);

        // R11 test register
        wr(11, 1, 32'h5);
        rd(11, 0, v); chk("R11 set op ignored", v, '0);
        wr(11, 3, 32'hA5);
        rd(11, 0, v); chk("R11 load", v, 32'hA5);
        wr(11, 3, 32'h0);

        // R3 R10 R4 rising edge on source 0
        wr(0, 1, 32'h1); wr(6, 1, 32'h1);
        src_int_i[0] = 1'b1;
        idle(2); chk("R10 edge not yet", N'(req0_o), '0);
        idle(1); chk("R10 edge captured", N'(req0_o), 32'h1);
        chk("R6 req1 idle", N'(req1_o), '0);
        src_int_i[0] = 1'b0;
        idle(4); chk("R4 capture held", N'(req0_o), 32'h1);
        rd(8, 0, v); chk("R3 rising mode ignores fall", v, '0);
        wr(7, 2, 32'h1);
        chk("R4 cleared", N'(req0_o), '0);

        // R4 set wins over simultaneous clear
        src_int_i[0] = 1'b1;
        idle(2);
        wr(7, 2, 32'h1);
        rd(7, 0, v); chk("R4 set wins", v, 32'h1);
        src_int_i[0] = 1'b0;
        idle(3);
        wr(7, 2, 32'h1); wr(6, 2, 32'h1); wr(0, 2, 32'h1);

        // R3 falling edge on source 1, routed to request 1
        wr(1, 1, 32'h2); wr(4, 2, 32'h2); wr(6, 1, 32'h2);
        src_int_i[1] = 1'b1;
        idle(4); chk("R3 falling mode ignores rise", N'(req1_o), '0);
        src_int_i[1] = 1'b0;
        idle(3); chk("R6 req1 from fall", N'(req1_o), 32'h1);
        chk("R6 req0 unrouted", N'(req0_o), '0);
        rd(10, 0, v); chk("R6 status1", v, 32'h2);
        wr(8, 2, 32'h2);
        chk("R4 fall cleared", N'(req1_o), '0);

        // R3 both edges on source 1
        wr(0, 1, 32'h2);
        src_int_i[1] = 1'b1;
        idle(3); chk("R3 both rise", N'(req1_o), 32'h1);
        rd(7, 0, v); chk("R3 both rise cap", v, 32'h2);
        wr(7, 2, 32'h2);
        src_int_i[1] = 1'b0;
        idle(3);
        rd(8, 0, v); chk("R3 both fall cap", v, 32'h2);
        wr(8, 2, 32'h2); wr(0, 2, 32'h2); wr(1, 2, 32'h2); wr(6, 2, 32'h2);

        // R5 R10 high level on source 2
        wr(2, 1, 32'h4); wr(0, 1, 32'h4); wr(6, 1, 32'h4);
        src_int_i[2] = 1'b1;
        idle(1); chk("R10 level not yet", N'(req0_o), '0);
        idle(1); chk("R10 level after two edges", N'(req0_o), 32'h1);
        rd(7, 0, v); chk("R5 level no capture", v, '0);
        src_int_i[2] = 1'b0;
        idle(2); chk("R5 level follows input", N'(req0_o), '0);

        // R8 bank select
        src_int_i[2] = 1'b1;
        idle(2);
        wr(3, 2, 32'h4);
        chk("R8 external bank low", N'(req0_o), '0);
        src_ext_i[2] = 1'b1;
        idle(2); chk("R8 external bank high", N'(req0_o), 32'h1);
        wr(3, 1, 32'h4);
        src_int_i[2] = 1'b0;
        idle(2); chk("R8 internal bank again", N'(req0_o), '0);
        src_ext_i[2] = 1'b0;
        wr(2, 2, 32'h4); wr(0, 2, 32'h4); wr(6, 2, 32'h4);

        // R7 low level with wake on source 3
        wr(2, 1, 32'h8); wr(1, 1, 32'h8);
        chk("R6 masked off", N'(req0_o), '0);
        wr(5, 1, 32'h8);
        chk("R7 wake ignores mask", N'(wake_o), 32'h1);
        wr(6, 1, 32'h8);
        chk("R6 req0 low level", N'(req0_o), 32'h1);
        rd(9, 0, v); chk("R6 status0", v, 32'h8);
        src_int_i[3] = 1'b1;
        idle(2); chk("R7 wake drops", N'(wake_o), '0);

        // R3 reserved code 111 on source 4
        wr(0, 1, 32'h10); wr(1, 1, 32'h10); wr(2, 1, 32'h10); wr(6, 1, 32'h10);
        src_int_i[4] = 1'b1;
        idle(3); chk("R3 code 111 silent", N'(req0_o), '0);
        src_int_i[4] = 1'b0;
        idle(3);
        rd(7, 0, v); chk("R3 code 111 no capture", v, '0);

        idle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule